// File: doc/BRIEF.md
# Half-Duplex Command/Acknowledge Sequencer

This block lives on the logic side of a 32-bit synchronous slave-FIFO link to a USB bridge. The link is half-duplex, so one set of data pins carries traffic both ways. When user logic pulses `start`, the block pulls an eight-word (32-byte) command frame out of the bridge's read socket. It then presents that frame on `cmd_payload`. Next it keeps the bus quiet for a turnaround interval. Finally it pushes the eight-word acknowledge frame from `ack_payload` into the bridge's write socket as a short packet.

The turnaround interval is requested at run time but never drops below a floor of 20 clocks. Shorter gaps have been seen to lose the leading word of the reply. Writing may not begin until the bridge has shown that its read buffer has drained, which it does by dropping the ready flag. After that, each word is strobed only while both the ready flag and the watermark flag are high. The packet-end strobe goes out with the last word, so no zero word is appended after the reply.

Top module: `sfifo_cmd_ack`

## Requirements
- R1: While reset is held, all active-low strobes (`cs_n`, `rd_n`, `wr_n`, `oe_n`, `pktend_n`) are high and `bus_doe`, `busy` and `done` are low.
- R2: After `start`, `rd_n` is low for exactly 8 consecutive cycles, with `cs_n` and `oe_n` low and `sock_addr` = 0. The word on `bus_din` two cycles after the k-th read-strobe cycle (k = 0..7) appears on `cmd_payload[32k+31:32k]`.
- R3: Let eff = max(`turn_len`, 20). The first write-strobe cycle comes at least eff+4 cycles after the last read-strobe cycle. When the flags already permit it, the write starts exactly then.
- R4: No write strobe occurs until `flag_rdy` has been seen low after the read burst. If it never drops, the block waits indefinitely.
- R5: Exactly 8 write strobes carry `ack_payload` words 0..7 in order on `bus_dout`, with `sock_addr` = 3, `bus_doe` high and `cs_n` low.
- R6: `pktend_n` is low together with the eighth write strobe and at no other time.
- R7: A write strobe is issued only while `flag_rdy` and `flag_wm` are both high. While paused, the current word is held. With a pause of W cycles, the write burst spans 7+W cycles.
- R8: `done` is high for one cycle, the cycle after the eighth write strobe. `busy` is high from the cycle after `start` through the `done` cycle and low afterwards.
- R9: `rd_n` and `wr_n` are never low together. `bus_doe` is never high while `oe_n` is low. `oe_n` stays high in the cycle after any cycle with `bus_doe` high.
- R10: A `start` pulse while `busy` is high is ignored: exactly 8 read strobes occur per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, 100 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one command/acknowledge exchange |
| turn_len | input | 8 | Requested read-to-write turnaround in clocks (floor 20) |
| ack_payload | input | 256 | Acknowledge frame, word k at bits [32k+31:32k] |
| cmd_payload | output | 256 | Received command frame, word k at bits [32k+31:32k] |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_din | input | 32 | Data bus, inbound half |
| bus_dout | output | 32 | Data bus, outbound half |
| bus_doe | output | 1 | Drive enable for the outbound half |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Bridge output enable, active low |
| pktend_n | output | 1 | Packet-end strobe, active low |
| sock_addr | output | 2 | Socket select: 0 read, 3 write |
| flag_rdy | input | 1 | Bridge buffer-ready flag |
| flag_wm | input | 1 | Bridge watermark flag |

## Verification
The bench sweeps the requested turnaround across values below, at and above the floor, including 0, 15, 19, 20 and 255. It also varies how long the ready flag stays low after the read. A design that ignored the floor or counted one cycle short would start the write early, and the exact gap check catches that. A watermark drop in mid-burst exposes a design that advances the word while paused: it would skip or repeat a word and stretch the burst incorrectly. Two further cases cover the remaining failures. In one, the ready flag is held high to show that the write is not issued before a drain is seen. In the other, a stray start during turnaround would cause a second read burst if it were not ignored.

// File: rtl/sfca_pkg.sv
package sfca_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_TURN, ST_WAITRDY, ST_WRITE, ST_DONE
  } sfca_state_e;

  // effective turnaround: the request, raised to the floor
  function automatic int unsigned eff_turn(input int unsigned req, input int unsigned floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction
endpackage

// File: rtl/sfca_ctrl.sv
module sfca_ctrl import sfca_pkg::*; #(
  parameter int TW       = 8,
  parameter int MIN_TURN = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] turn_len,
  input  logic          rd_done,
  input  logic          wr_done,
  input  logic          flag_rdy,
  output sfca_state_e   state,
  output logic [TW-1:0] eff_len
);
  logic [TW-1:0] tcnt;
  logic          drained;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tcnt    <= '0;
      eff_len <= TW'(MIN_TURN);
      drained <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          eff_len <= TW'(eff_turn(32'(turn_len), MIN_TURN));
          state   <= ST_READ;
        end
        ST_READ: if (rd_done) begin
          tcnt    <= '0;
          drained <= 1'b0;
          state   <= ST_TURN;
        end
        ST_TURN: begin
          tcnt <= tcnt + 1'b1;
          if (!flag_rdy) drained <= 1'b1;
          if (tcnt == eff_len - 1'b1) state <= ST_WAITRDY;
        end
        ST_WAITRDY: if (drained || !flag_rdy) state <= ST_WRITE;
        ST_WRITE:   if (wr_done) state <= ST_DONE;
        ST_DONE:    state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  AST_FLOOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (eff_len >= TW'(MIN_TURN))) else $error("turn floor"); // R3
endmodule

// File: rtl/sfca_rd.sv
module sfca_rd #(
  parameter int DW     = 32,
  parameter int WORDS  = 8,
  parameter int RD_LAT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic [DW-1:0]       bus_din,
  output logic                rd_strobe,
  output logic                cap_last,
  output logic [WORDS*DW-1:0] cmd_flat
);
  localparam int IW = $clog2(WORDS + 1);

  logic [IW-1:0]     rcnt, ccnt;
  logic [RD_LAT-1:0] pipe;
  logic              capture;

  assign rd_strobe = active && (rcnt < IW'(WORDS));
  assign capture   = pipe[RD_LAT-1];
  assign cap_last  = capture && (ccnt == IW'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt <= '0;
      ccnt <= '0;
      pipe <= '0;
    end else begin
      pipe[0] <= rd_strobe;
      for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
      if (!active)        rcnt <= '0;
      else if (rd_strobe) rcnt <= rcnt + 1'b1;
      if (!active)        ccnt <= '0;
      else if (capture)   ccnt <= ccnt + 1'b1;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                               word_q <= '0;
      else if (capture && ccnt == IW'(w))       word_q <= bus_din;
    end
    assign cmd_flat[w*DW +: DW] = word_q;
  end

  AST_RD_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(rd_strobe) && !rd_strobe) |=> !rd_strobe) else $error("burst restart"); // R2
endmodule

// File: rtl/sfca_wr.sv
module sfca_wr #(
  parameter int DW    = 32,
  parameter int WORDS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                flag_rdy,
  input  logic                flag_wm,
  input  logic [WORDS*DW-1:0] ack_flat,
  output logic                wr_strobe,
  output logic                wr_last,
  output logic [DW-1:0]       dout,
  output logic                doe
);
  localparam int IW = $clog2(WORDS);

  logic [IW-1:0] widx;

  assign wr_strobe = active && flag_rdy && flag_wm;
  assign wr_last   = wr_strobe && (widx == IW'(WORDS - 1));
  assign dout      = ack_flat[widx*DW +: DW];
  assign doe       = active;

  always_ff @(posedge clk) begin
    if (!rst_n)         widx <= '0;
    else if (!active)   widx <= '0;
    else if (wr_strobe) widx <= widx + 1'b1;
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(wr_strobe)) |-> $stable(dout)) else $error("word moved"); // R7
endmodule

// File: rtl/sfifo_cmd_ack.sv
module sfifo_cmd_ack import sfca_pkg::*; #(
  parameter int         DW       = 32,
  parameter int         WORDS    = 8,
  parameter int         TW       = 8,
  parameter int         MIN_TURN = 20,
  parameter int         RD_LAT   = 2,
  parameter logic [1:0] RD_SOCK  = 2'd0,
  parameter logic [1:0] WR_SOCK  = 2'd3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [TW-1:0]       turn_len,
  input  logic [WORDS*DW-1:0] ack_payload,
  output logic [WORDS*DW-1:0] cmd_payload,
  output logic                busy,
  output logic                done,
  input  logic [DW-1:0]       bus_din,
  output logic [DW-1:0]       bus_dout,
  output logic                bus_doe,
  output logic                cs_n,
  output logic                rd_n,
  output logic                wr_n,
  output logic                oe_n,
  output logic                pktend_n,
  output logic [1:0]          sock_addr,
  input  logic                flag_rdy,
  input  logic                flag_wm
);
  sfca_state_e   state;
  logic [TW-1:0] eff_len;
  logic          rd_strobe, rd_done, wr_strobe, wr_last;

  sfca_ctrl #(.TW(TW), .MIN_TURN(MIN_TURN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .turn_len(turn_len),
    .rd_done(rd_done), .wr_done(wr_last), .flag_rdy(flag_rdy),
    .state(state), .eff_len(eff_len));

  sfca_rd #(.DW(DW), .WORDS(WORDS), .RD_LAT(RD_LAT)) u_rd (
    .clk(clk), .rst_n(rst_n), .active(state == ST_READ), .bus_din(bus_din),
    .rd_strobe(rd_strobe), .cap_last(rd_done), .cmd_flat(cmd_payload));

  sfca_wr #(.DW(DW), .WORDS(WORDS)) u_wr (
    .clk(clk), .rst_n(rst_n), .active(state == ST_WRITE),
    .flag_rdy(flag_rdy), .flag_wm(flag_wm), .ack_flat(ack_payload),
    .wr_strobe(wr_strobe), .wr_last(wr_last), .dout(bus_dout), .doe(bus_doe));

  assign rd_n      = !rd_strobe;
  assign wr_n      = !wr_strobe;
  assign pktend_n  = !wr_last;
  assign oe_n      = !(state == ST_READ);
  assign cs_n      = !(state == ST_READ || state == ST_WRITE);
  assign sock_addr = (state == ST_IDLE || state == ST_READ) ? RD_SOCK : WR_SOCK;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);

  // observation wires for the assertions
  logic [15:0] gap_cnt;   // cycles since the last read strobe
  logic        seen_low;  // ready flag seen low since the last read strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt  <= '0;
      seen_low <= 1'b0;
    end else begin
      if (rd_strobe)           gap_cnt <= '0;
      else if (gap_cnt != '1)  gap_cnt <= gap_cnt + 1'b1;
      if (rd_strobe)           seen_low <= 1'b0;
      else if (!flag_rdy)      seen_low <= 1'b1;
    end
  end

  AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)) else $error("both strobes"); // R9
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_doe) |-> oe_n) else $error("no release cycle"); // R9
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (gap_cnt >= 16'(eff_len) + 16'd3)) else $error("turnaround short"); // R3
  AST_DRAIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> seen_low) else $error("write before drain"); // R4
  AST_PKTEND_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !pktend_n |=> done) else $error("no done"); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)) else $error("done width"); // R8
endmodule

// File: tb/test_sfifo_cmd_ack.sv
module test_sfifo_cmd_ack;
  localparam int DW = 32, WORDS = 8, TW = 8, MIN_TURN = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst_n = 1'b0, start = 1'b0;
  logic [TW-1:0]       turn_len = '0;
  logic [WORDS*DW-1:0] ack_payload = '0;
  wire  [WORDS*DW-1:0] cmd_payload;
  wire                 busy, done, bus_doe, cs_n, rd_n, wr_n, oe_n, pktend_n;
  logic [DW-1:0]       bus_din = '0;
  wire  [DW-1:0]       bus_dout;
  wire  [1:0]          sock_addr;
  logic                model_rdy = 1'b1, force_low = 1'b0;
  logic [7:0]          wm_cnt = '0;
  wire                 flag_rdy = model_rdy && !force_low;
  wire                 flag_wm  = (wm_cnt == 0);

  sfifo_cmd_ack i_sfifo_cmd_ack (
    .clk(clk), .rst_n(rst_n), .start(start), .turn_len(turn_len),
    .ack_payload(ack_payload), .cmd_payload(cmd_payload), .busy(busy), .done(done),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .oe_n(oe_n), .pktend_n(pktend_n),
    .sock_addr(sock_addr), .flag_rdy(flag_rdy), .flag_wm(flag_wm));

  int nchk = 0, nfail = 0;
  // bridge model state
  logic        clr = 1'b0, d1 = 1'b0, hold_high = 1'b0;
  int          cyc = 0, rptr = 0, rd_cnt = 0, first_rd = 0, last_rd = 0, lc = 0;
  int          rx_cnt = 0, first_wr = 0, last_wr = 0, pkt_cnt = 0, pkt_idx = -1;
  int          rdy_low = 2, wm_at = 0, wm_len = 0;
  logic [31:0] cmd_mem [WORDS];
  logic [31:0] rx [16];
  int          duplex_bad = 0, release_bad = 0, addr_bad = 0;
  logic        prev_doe = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wm_cnt != 0) wm_cnt <= wm_cnt - 1;
    if (clr) begin
      d1 <= 1'b0; rptr <= 0; rd_cnt <= 0; rx_cnt <= 0; pkt_cnt <= 0; pkt_idx <= -1;
      model_rdy <= 1'b1; wm_cnt <= '0;
    end else begin
      d1 <= !rd_n;
      if (!rd_n) begin
        if (rd_cnt == 0) first_rd <= cyc;
        last_rd <= cyc;
        rd_cnt  <= rd_cnt + 1;
      end
      if (d1 && rptr < WORDS) begin
        bus_din <= cmd_mem[rptr];
        rptr    <= rptr + 1;
        if (rptr == WORDS - 1 && !hold_high) begin
          model_rdy <= 1'b0;
          lc        <= rdy_low - 1;
        end
      end else if (!model_rdy) begin
        if (lc == 0) model_rdy <= 1'b1;
        else         lc <= lc - 1;
      end
      if (!wr_n && !cs_n) begin
        if (rx_cnt < 16) rx[rx_cnt] <= bus_dout;
        if (rx_cnt == 0) first_wr <= cyc;
        last_wr <= cyc;
        rx_cnt  <= rx_cnt + 1;
        if (!pktend_n) begin pkt_cnt <= pkt_cnt + 1; pkt_idx <= rx_cnt; end
        if (rx_cnt + 1 == wm_at) wm_cnt <= 8'(wm_len);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!rd_n && !wr_n) duplex_bad++;
      if ((bus_doe && !oe_n) || (prev_doe && !oe_n)) release_bad++;
      if (!rd_n && (oe_n || cs_n || sock_addr != 2'd0)) addr_bad++;
      if (!wr_n && (sock_addr != 2'd3 || !bus_doe || cs_n || !oe_n)) addr_bad++;
    end
    prev_doe = bus_doe;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int t, input int rl, input int wat, input int wl,
                     input bit stuck, input bit restart);
    int eff, exp_gap, guard;
    turn_len = TW'(t); rdy_low = rl; wm_at = wat; wm_len = wl; hold_high = stuck;
    for (int k = 0; k < WORDS; k++) begin
      cmd_mem[k] = 32'hC0000000 + 32'(t) * 32'h100 + 32'(k) * 32'h11 + 32'h1;
      ack_payload[k*DW +: DW] = 32'h5A000000 ^ (32'(t) << 12) ^ (32'(k + 1) * 32'h01010101);
    end
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (restart) begin
      repeat (12) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    if (stuck) begin
      repeat (150) @(negedge clk);
      chk(rx_cnt == 0, "R4 write held without drain", rx_cnt, 0);
      force_low = 1'b1;
      @(negedge clk) force_low = 1'b0;
    end
    guard = 0;
    while (!done && guard < 3000) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R8 done seen", done, 1);
    @(negedge clk);
    chk(!done && !busy, "R8 done one cycle then idle", {done, busy}, 0);
    repeat (20) @(negedge clk);
    chk(rd_cnt == WORDS, "R2 R10 read strobe count", rd_cnt, WORDS);
    chk(last_rd - first_rd == WORDS - 1, "R2 contiguous burst", last_rd - first_rd, WORDS - 1);
    for (int k = 0; k < WORDS; k++)
      chk(cmd_payload[k*DW +: DW] == cmd_mem[k], "R2 command word",
          cmd_payload[k*DW +: DW], cmd_mem[k]);
    chk(rx_cnt == WORDS, "R5 write count", rx_cnt, WORDS);
    for (int k = 0; k < WORDS; k++)
      chk(rx[k] == ack_payload[k*DW +: DW], "R5 ack word order", rx[k], ack_payload[k*DW +: DW]);
    chk(pkt_cnt == 1 && pkt_idx == WORDS - 1, "R6 packet end on last word", pkt_idx, WORDS - 1);
    chk(last_wr - first_wr == WORDS - 1 + wl, "R7 burst span with pause",
        last_wr - first_wr, WORDS - 1 + wl);
    if (!stuck) begin
      eff     = (t < MIN_TURN) ? MIN_TURN : t;
      exp_gap = (eff + 4 > rl + 2) ? eff + 4 : rl + 2;
      chk(first_wr - last_rd == exp_gap, "R3 turnaround gap", first_wr - last_rd, exp_gap);
    end
  endtask

  initial begin
    int turns [9] = '{0, 1, 15, 19, 20, 21, 33, 128, 255};
    repeat (3) @(negedge clk);
    chk({cs_n, rd_n, wr_n, oe_n, pktend_n} == 5'b11111 && !bus_doe && !busy && !done,
        "R1 reset state", {cs_n, rd_n, wr_n, oe_n, pktend_n, bus_doe, busy, done}, 8'hF8);
    rst_n = 1'b1;
    foreach (turns[i])
      for (int rl = 2; rl <= 40; rl += 38)
        for (int wm = 0; wm < 2; wm++)
          run(turns[i], rl, wm ? 3 : 0, wm ? 1 + turns[i] % 5 : 0, 1'b0, 1'b0);
    run(20, 2, 0, 0, 1'b1, 1'b0);   // R4 ready never drops on its own
    run(25, 2, 5, 2, 1'b0, 1'b1);   // R10 stray start during turnaround
    chk(duplex_bad == 0, "R9 strobes never overlap", duplex_bad, 0);
    chk(release_bad == 0, "R9 bus release", release_bad, 0);
    chk(addr_bad == 0, "R2 R5 socket and enables", addr_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule